// File: doc/BRIEF.md
# Timer Tick Prescaler and Divider Select

This block turns one system clock into a set of per-channel tick enables for a bank of five countdown timers. The channels are split into two groups. Each group has an 8-bit prescaler that divides the system clock. Every channel then applies its own power-of-two divide to its group's prescaler output. A channel can instead follow an external clock input, and each group has its own external clock.

The configuration comes from two 32-bit words that a register block outside this design holds. The prescaler word carries one 8-bit field per group. The selector word carries one 4-bit code per channel. External clocks are treated as slow, asynchronous signals: they are sampled, not used as clocks, so no clock gating or clock switching takes place. Every output is a one-cycle enable, registered on the system clock, and the timers use it to decrement.

Configuration changes are picked up at a group's prescaler terminal count. As a result, a channel's running period is never cut short.

Top module: `tmr_tick_mux`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, every bit of `tick_o` is 0.
- R2: A prescaler field of value P makes the group advance once every P+1 system clock cycles. A channel in divided mode that uses selector code c emits one tick every (P+1)·2^(c+DIV_BASE) cycles. With the default DIV_BASE of 1, codes 0, 1, 2 and 3 give gaps of 2, 4, 8 and 16 prescaler steps.
- R3: Group 0 uses `cfg_psc_i[7:0]` and contains channels 0 and 1. Group 1 uses `cfg_psc_i[15:8]` and contains channels 2, 3 and 4. Changing one group's field leaves the tick spacing of the other group's channels unchanged.
- R4: The selector code of channel n sits at `cfg_sel_i[4n+3:4n]`. A code that is not in EXT_MASK and whose exponent c+DIV_BASE is above 4 is clamped to a divide of 16. With the defaults, code 5 therefore gives 16 prescaler steps.
- R5: A selector code whose bit is set in EXT_MASK routes the group's external clock to the channel. The default mask sets only code 4. Channels 0 and 1 follow `ext_clk_i[0]`, and channels 2 to 4 follow `ext_clk_i[1]`. The input passes through a two-flop synchroniser, and each rising edge gives exactly one tick. Toggling the other group's external clock produces no tick on the channel.
- R6: Every tick lasts exactly one cycle whenever the selected divide is 2 or more, or the channel is in external mode.
- R7: A change to a prescaler field or a selector code takes effect at the group's next terminal count. No gap between two ticks of the affected channel is shorter than the smaller of its old and new periods. Once the change has settled, the gap equals the new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; the current configuration is loaded while it is held |
| cfg_psc_i | input | 32 | Prescaler word: group 0 in bits 7:0, group 1 in bits 15:8 |
| cfg_sel_i | input | 32 | Selector word: one 4-bit code per channel, channel n at bit 4n |
| ext_clk_i | input | 2 | External clocks, asynchronous: bit 0 for group 0, bit 1 for group 1 |
| tick_o | output | 5 | One-cycle tick enable per channel, registered |

## Verification
The bench builds the block with its default parameters. These give five channels, two groups, a base exponent of 1 (minimum divide 2) and only code 4 routed to the external clock. With these values, one run exercises all four divided codes, the clamp of an out-of-range code and the external route for both groups. Small prescaler values keep every period under a few hundred cycles, so gap measurements of both the steady state and a change in progress fit in a short run. Because the base exponent is 1, no code gives back-to-back ticks, so the one-cycle pulse property holds for every channel in every mode.

// File: rtl/tmr_tick_pkg.sv
package tmr_tick_pkg;

  // Group index of a channel: channels below the split belong to group 0.
  function automatic int unsigned grp_of(input int unsigned ch, input int unsigned split);
    return (ch < split) ? 0 : 1;
  endfunction

  // Power-of-two exponent for a selector code, clamped to the largest divide.
  function automatic int unsigned div_exp(input int unsigned code, input int unsigned base,
                                          input int unsigned max_exp);
    int unsigned e;
    e = code + base;
    return (e > max_exp) ? max_exp : e;
  endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int unsigned PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PSC_W-1:0] psc_cfg_i,
  output logic             tc_o
);
  logic [PSC_W-1:0] cnt_q;
  logic [PSC_W-1:0] lim_q;

  assign tc_o = (cnt_q == lim_q);

  // Limit reloads only at terminal count, so a running period is never cut.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      lim_q <= psc_cfg_i;
    end else if (tc_o) begin
      cnt_q <= '0;
      lim_q <= psc_cfg_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tick_ext_sync.sv
module tick_ext_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_i,
  output logic rise_o
);
  localparam int unsigned DEPTH = SYNC_STAGES + 1;

  logic [DEPTH-1:0] shf_q;

  always_ff @(posedge clk) begin
    if (rst) shf_q <= '0;
    else     shf_q <= {shf_q[DEPTH-2:0], ext_i};
  end

  assign rise_o = shf_q[DEPTH-2] & ~shf_q[DEPTH-1];
endmodule

// File: rtl/tick_chan_div.sv
module tick_chan_div
  import tmr_tick_pkg::*;
#(
  parameter int unsigned         SEL_W    = 4,
  parameter int unsigned         DIV_BASE = 1,
  parameter int unsigned         MAX_EXP  = 4,
  parameter logic [(1<<SEL_W)-1:0] EXT_MASK = 16'h0010
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel_cfg_i,
  input  logic             grp_tc_i,
  input  logic             ext_rise_i,
  output logic             ext_mode_o,
  output logic             tick_o
);
  logic [SEL_W-1:0]   sel_q;
  logic [MAX_EXP-1:0] div_q;
  logic [MAX_EXP-1:0] msk;
  logic               hit;
  logic               tick_d;

  always_comb begin
    int unsigned e;
    e   = div_exp(int'(sel_q), DIV_BASE, MAX_EXP);
    msk = MAX_EXP'((32'd1 << e) - 32'd1);
  end

  assign hit        = grp_tc_i && ((div_q & msk) == msk);
  assign ext_mode_o = EXT_MASK[sel_q];
  assign tick_d     = ext_mode_o ? ext_rise_i : hit;

  // Selector is taken at the group terminal count; a new code restarts the count.
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= sel_cfg_i;
      div_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= tick_d;
      if (grp_tc_i) begin
        if (sel_cfg_i != sel_q) begin
          sel_q <= sel_cfg_i;
          div_q <= '0;
        end else if (hit) begin
          div_q <= '0;
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tmr_tick_mux.sv
module tmr_tick_mux
  import tmr_tick_pkg::*;
#(
  parameter int unsigned           NUM_CH   = 5,
  parameter int unsigned           GRP0_CH  = 2,
  parameter int unsigned           PSC_W    = 8,
  parameter int unsigned           SEL_W    = 4,
  parameter int unsigned           CFG_W    = 32,
  parameter int unsigned           DIV_BASE = 1,
  parameter int unsigned           MAX_EXP  = 4,
  parameter logic [(1<<SEL_W)-1:0] EXT_MASK = 16'h0010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CFG_W-1:0]  cfg_psc_i,
  input  logic [CFG_W-1:0]  cfg_sel_i,
  input  logic [1:0]        ext_clk_i,
  output logic [NUM_CH-1:0] tick_o
);
  localparam int unsigned NUM_GRP  = 2;
  localparam int unsigned PSC_USED = NUM_GRP * PSC_W;
  localparam int unsigned SEL_USED = NUM_CH * SEL_W;

  logic [NUM_GRP-1:0] grp_tc;
  logic [NUM_GRP-1:0] ext_rise;
  logic [NUM_CH-1:0]  ch_ext;
  logic               unused_cfg;

  assign unused_cfg = ^{cfg_psc_i[CFG_W-1:PSC_USED], cfg_sel_i[CFG_W-1:SEL_USED]};

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    tick_prescaler #(.PSC_W(PSC_W)) u_psc (
      .clk       (clk),
      .rst       (rst),
      .psc_cfg_i (cfg_psc_i[g*PSC_W +: PSC_W]),
      .tc_o      (grp_tc[g])
    );
    tick_ext_sync #(.SYNC_STAGES(2)) u_sync (
      .clk    (clk),
      .rst    (rst),
      .ext_i  (ext_clk_i[g]),
      .rise_o (ext_rise[g])
    );
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    localparam int unsigned G = grp_of(n, GRP0_CH);
    tick_chan_div #(
      .SEL_W    (SEL_W),
      .DIV_BASE (DIV_BASE),
      .MAX_EXP  (MAX_EXP),
      .EXT_MASK (EXT_MASK)
    ) u_div (
      .clk        (clk),
      .rst        (rst),
      .sel_cfg_i  (cfg_sel_i[n*SEL_W +: SEL_W]),
      .grp_tc_i   (grp_tc[G]),
      .ext_rise_i (ext_rise[G]),
      .ext_mode_o (ch_ext[n]),
      .tick_o     (tick_o[n])
    );
  end
endmodule

// File: rtl/tmr_tick_mux_chk.sv
module tmr_tick_mux_chk
  import tmr_tick_pkg::*;
#(
  parameter int unsigned NUM_CH   = 5,
  parameter int unsigned GRP0_CH  = 2,
  parameter int unsigned DIV_BASE = 1
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] tick_o,
  input logic [1:0]        grp_tc,
  input logic [1:0]        grp_rise,
  input logic [NUM_CH-1:0] ch_ext
);
  assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> (tick_o == '0));

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
    localparam int unsigned G = grp_of(n, GRP0_CH);

    assert_tick_on_tc_R2: assert property (@(posedge clk) disable iff (rst)
      (tick_o[n] && !$past(ch_ext[n])) |-> $past(grp_tc[G]));

    assert_tick_on_edge_R5: assert property (@(posedge clk) disable iff (rst)
      (tick_o[n] && $past(ch_ext[n])) |-> $past(grp_rise[G]));

    if (DIV_BASE > 0) begin : g_pulse
      assert_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        tick_o[n] |=> !tick_o[n]);
    end
  end
endmodule

bind tmr_tick_mux tmr_tick_mux_chk #(
  .NUM_CH   (NUM_CH),
  .GRP0_CH  (GRP0_CH),
  .DIV_BASE (DIV_BASE)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick_o   (tick_o),
  .grp_tc   (grp_tc),
  .grp_rise (ext_rise),
  .ch_ext   (ch_ext)
);

// File: tb/test_tmr_tick_mux.sv
module test_tmr_tick_mux;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cfg_psc = '0;
  logic [31:0] cfg_sel = '0;
  logic [1:0]  ext_clk = '0;
  logic [4:0]  tick;

  int total = 0;
  int bad = 0;
  int hp0 = 0;
  int hp1 = 0;
  int dbl_hits = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  tmr_tick_mux i_tmr_tick_mux (
    .clk       (clk),
    .rst       (rst),
    .cfg_psc_i (cfg_psc),
    .cfg_sel_i (cfg_sel),
    .ext_clk_i (ext_clk),
    .tick_o    (tick)
  );

  // External clock generators, toggled just after an edge with a half period in cycles.
  initial begin
    int k = 0;
    forever begin
      @(posedge clk); #1;
      if (hp0 == 0) begin ext_clk[0] = 1'b0; k = 0; end
      else begin k++; if (k >= hp0) begin ext_clk[0] = ~ext_clk[0]; k = 0; end end
    end
  end
  initial begin
    int k = 0;
    forever begin
      @(posedge clk); #1;
      if (hp1 == 0) begin ext_clk[1] = 1'b0; k = 0; end
      else begin k++; if (k >= hp1) begin ext_clk[1] = ~ext_clk[1]; k = 0; end end
    end
  end

  // Pulse-width monitor for R6: a tick high in two sampled cycles in a row.
  initial begin
    logic [4:0] prev = '0;
    forever begin
      @(negedge clk);
      if (!rst && ((prev & tick) != '0)) dbl_hits++;
      prev = rst ? 5'b0 : tick;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sel_word(input int c0, input int c1, input int c2,
                                           input int c3, input int c4);
    return {12'h0, 4'(c4), 4'(c3), 4'(c2), 4'(c1), 4'(c0)};
  endfunction

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Cycles between two consecutive ticks of one channel, -1 on timeout.
  task automatic gap_of(input int ch, output int gap);
    int n;
    gap = -1;
    n = 0;
    do begin @(negedge clk); n++; end while (!tick[ch] && n < 3000);
    if (!tick[ch]) return;
    n = 0;
    do begin @(negedge clk); n++; end while (!tick[ch] && n < 3000);
    if (tick[ch]) gap = n;
  endtask

  task automatic count_ticks(input int ch, input int win, output int cnt);
    cnt = 0;
    for (int i = 0; i < win; i++) begin @(negedge clk); if (tick[ch]) cnt++; end
  endtask

  task automatic t_reset;
    int seen = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); if (tick != '0) seen++; end
    check("R1 tick_o quiet in reset", seen, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 tick_o first cycle after reset", int'(tick), 0);
  endtask

  task automatic t_divide;
    int g;
    cfg_psc = 32'h0000_0002;                   // group0 P=2, group1 P=0
    cfg_sel = sel_word(0, 3, 1, 2, 0);
    wait_cyc(120);
    gap_of(0, g); check("R2 ch0 P=2 code0", g, 3*2);
    gap_of(1, g); check("R2 ch1 P=2 code3", g, 3*16);
    gap_of(2, g); check("R4 ch2 P=0 code1", g, 4);
    gap_of(3, g); check("R4 ch3 P=0 code2", g, 8);
    gap_of(4, g); check("R2 ch4 P=0 code0", g, 2);
  endtask

  task automatic t_groups;
    int g;
    cfg_psc = 32'h0000_0402;                   // group1 P=4
    wait_cyc(120);
    gap_of(0, g); check("R3 ch0 unaffected by group1", g, 6);
    gap_of(1, g); check("R3 ch1 unaffected by group1", g, 48);
    gap_of(2, g); check("R3 ch2 follows group1", g, 5*4);
    gap_of(4, g); check("R3 ch4 follows group1", g, 5*2);
  endtask

  task automatic t_clamp;
    int g;
    cfg_psc = 32'h0000_0000;
    cfg_sel = sel_word(5, 15, 0, 0, 0);
    wait_cyc(80);
    gap_of(0, g); check("R4 code5 clamped to 16", g, 16);
    gap_of(1, g); check("R4 code15 clamped to 16", g, 16);
  endtask

  task automatic t_ext;
    int g;
    int c;
    cfg_psc = 32'h0000_0000;
    cfg_sel = sel_word(4, 0, 4, 1, 4);
    hp0 = 0; hp1 = 5;
    wait_cyc(60);
    count_ticks(0, 120, c); check("R5 ch0 ignores ext clock 1", c, 0);
    gap_of(2, g); check("R5 ch2 follows ext clock 1", g, 10);
    gap_of(4, g); check("R5 ch4 follows ext clock 1", g, 10);
    gap_of(3, g); check("R5 ch3 divided while group in ext", g, 4);
    hp0 = 7; hp1 = 0;
    wait_cyc(60);
    gap_of(0, g); check("R5 ch0 follows ext clock 0", g, 14);
    count_ticks(2, 120, c); check("R5 ch2 ignores ext clock 0", c, 0);
    gap_of(1, g); check("R5 ch1 divided while group in ext", g, 2);
    hp0 = 0;
    wait_cyc(20);
  endtask

  task automatic t_reconfig;
    int g;
    int mn;
    cfg_psc = 32'h0000_0102;                   // group0 P=2, group1 P=1
    cfg_sel = sel_word(0, 0, 0, 0, 0);
    wait_cyc(60);
    gap_of(3, g); check("R7 ch3 before code change", g, 4);
    cfg_sel = sel_word(0, 0, 0, 3, 0);
    mn = 100000;
    for (int i = 0; i < 4; i++) begin gap_of(3, g); if (g < mn) mn = g; end
    check("R7 no short gap on code change", int'(mn >= 4), 1);
    check("R7 settled gap after code change", g, 32);
    cfg_psc = 32'h0000_0106;                   // group0 P=6
    mn = 100000;
    for (int i = 0; i < 4; i++) begin gap_of(0, g); if (g < mn) mn = g; end
    check("R7 no short gap on prescaler change", int'(mn >= 6), 1);
    check("R7 settled gap after prescaler change", g, 14);
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 100000);
        finish_run();
      end
    end
  end

  initial begin
    t_reset();
    t_divide();
    t_groups();
    t_clamp();
    t_ext();
    t_reconfig();
    check("R6 single-cycle ticks", dbl_hits, 0);
    finish_run();
  end
endmodule